// File: doc/BRIEF.md
# Display Memory Byte-Write Adapter

This block takes write cycles from a 32-bit system bus and turns them into halfword updates of three display memories. Those memories are a colour palette store, a video store and an object attribute store. The top address byte picks the memory. The transfer size (byte, halfword or word) and, for the video store, the current background mode decide how the bus data lands in storage. The mode is a 3-bit value taken from the display controller.

Storage is halfword-granular. A byte write is never merged into memory by a byte mask:

- **Palette:** the byte is copied into both halves of the aligned halfword.
- **Video store:** the byte is copied the same way, unless it falls in the object tile area that is closed to byte writes for the current mode. In that case it is dropped.
- **Object attribute store:** a byte write is always dropped.

Halfword writes store one halfword. Word writes store two halfwords at once, with the low halfword at the lower address.

A read port returns the stored halfword at any address one cycle later, for checking.

Each memory is modelled as a small behavioural array of 32-bit words with two halfword lanes. The video store is held as six 16 KiB sections. Of each section, only the low `VSECT_KEEP_BYTES` bytes are backed by storage; higher offsets inside a section alias onto them. Address decoding, mirroring and filtering always work on the full address.

Top module: `dispmem_write_adapter`

## Requirements
- R1: Address bits 31:24 select the memory: 8'h05 palette, 8'h06 video store, 8'h07 object attribute store. A write with any other top byte changes no memory.
- R2: A byte write to the palette stores {b, b} (byte × 0x0101) into the halfword at the address with bit 0 cleared.
- R3: A byte write to the video store uses the same duplication and alignment as R2 when it is not filtered.
- R4: With bg_mode 0, 1 or 2, video byte writes to bus addresses 0x0601_0000 up to but not including 0x0601_8000 are dropped. Halfword and word writes there are stored.
- R5: With bg_mode 3 to 7, only video byte writes to 0x0601_4000 up to but not including 0x0601_8000 are dropped. Byte writes to 0x0601_0000 up to 0x0601_3FFF are stored.
- R6: The filter of R4 and R5 compares the bus address before mirroring. A byte write at 0x0601_8000 or above inside the window is stored, at its mirrored offset.
- R7: Every byte write to the object attribute store is dropped and leaves it unchanged.
- R8: Halfword writes ignore address bit 0. Word writes ignore bits 1:0 and store data[15:0] at the aligned address and data[31:16] at aligned address + 2. wr_size encodes 0 byte, 1 halfword, 2 word, 3 no write.
- R9: Palette and object attribute stores repeat every 1 KiB (PAL_BYTES, OAM_BYTES) across their region.
- R10: The video store window is 128 KiB and repeats across its region (address bits 23:17 ignored). Window offsets 0x18000 to 0x1FFFF map onto 0x10000 to 0x17FFF.
- R11: rd_data shows the halfword at rd_addr (bit 0 ignored) one cycle after rd_addr is presented. It is zero for unmapped top bytes, and zero during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read path |
| wr_en | input | 1 | Write strobe |
| wr_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 no write |
| wr_addr | input | 32 | Bus byte address of the write |
| wr_data | input | 32 | Write data; bytes in bits 7:0, halfwords in 15:0 |
| bg_mode | input | 3 | Background mode from the display controller |
| rd_addr | input | 32 | Check-port read address |
| rd_data | output | 16 | Halfword at the previous cycle's rd_addr |

## Verification
The embedded assertions watch every cycle for the following:

- at most one storage array is written per cycle;
- no array is written for a foreign top byte;
- a byte write inside the closed object tile area, for either mode class, never reaches the video sections;
- a byte write to the object attribute store never reaches it;
- an unmapped read returns zero on the next cycle.

Other behaviours change stored contents and so only the bench scenarios can show them, by writing and then reading back. These are byte duplication, alignment, word splitting, the mirroring of each region, and the fact that the filter uses the unmirrored address.

// File: rtl/dmw_pkg.sv
package dmw_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PAL  = 2'd1,
        TGT_VRAM = 2'd2,
        TGT_OAM  = 2'd3
    } target_e;

    localparam logic [7:0] PAL_PAGE  = 8'h05;
    localparam logic [7:0] VRAM_PAGE = 8'h06;
    localparam logic [7:0] OAM_PAGE  = 8'h07;

    // video window geometry (behavioural: 6 sections of 16 KiB)
    localparam int VSECT_COUNT = 6;
    localparam int VSECT_SHIFT = 14;

endpackage

// File: rtl/dmw_locate.sv
module dmw_locate
    import dmw_pkg::*;
#(
    parameter int PAL_BYTES = 1024,
    parameter int OAM_BYTES = 1024
) (
    input  logic [31:0] addr,
    output target_e     tgt,
    output logic [16:0] off
);
    localparam int PAL_AW = $clog2(PAL_BYTES);
    localparam int OAM_AW = $clog2(OAM_BYTES);

    logic unused_hi;
    assign unused_hi = ^addr[23:17];

    always_comb begin
        tgt = TGT_NONE;
        off = '0;
        unique case (addr[31:24])
            PAL_PAGE: begin
                tgt                = TGT_PAL;
                off[PAL_AW-1:0]    = addr[PAL_AW-1:0];
            end
            VRAM_PAGE: begin
                tgt = TGT_VRAM;
                off = addr[16:0];
                // top 32 KiB of the window folds onto the previous 32 KiB
                if (off[16:15] == 2'b11) begin
                    off[15] = 1'b0;
                end
            end
            OAM_PAGE: begin
                tgt                = TGT_OAM;
                off[OAM_AW-1:0]    = addr[OAM_AW-1:0];
            end
            default: begin
                tgt = TGT_NONE;
            end
        endcase
    end
endmodule

// File: rtl/dmw_shape.sv
module dmw_shape
    import dmw_pkg::*;
(
    input  logic        wr_en,
    input  logic [1:0]  wr_size,
    input  logic [31:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic [2:0]  bg_mode,
    input  target_e     tgt,
    output logic        commit,
    output logic [1:0]  lane_en,
    output logic [31:0] lane_data
);
    logic        keep;
    logic        in_obj_area;
    logic [15:0] half;
    xfer_size_e  size;

    logic unused_addr;
    assign unused_addr = ^{wr_addr[31:24], wr_addr[13:2], wr_addr[0]};

    assign size = xfer_size_e'(wr_size);

    // object tile area closed to byte writes, judged on the raw bus address
    always_comb begin
        in_obj_area = 1'b0;
        if (wr_addr[23:16] == 8'h01) begin
            if (bg_mode <= 3'd2) begin
                in_obj_area = ~wr_addr[15];
            end else begin
                in_obj_area = (wr_addr[15:14] == 2'b01);
            end
        end
    end

    always_comb begin
        keep      = 1'b0;
        half      = wr_data[15:0];
        lane_en   = 2'b00;
        lane_data = {wr_data[15:0], wr_data[15:0]};
        unique case (size)
            SZ_BYTE: begin
                half      = {wr_data[7:0], wr_data[7:0]};
                lane_data = {half, half};
                lane_en   = wr_addr[1] ? 2'b10 : 2'b01;
                keep      = (tgt != TGT_OAM) &&
                            !((tgt == TGT_VRAM) && in_obj_area);
            end
            SZ_HALF: begin
                lane_data = {half, half};
                lane_en   = wr_addr[1] ? 2'b10 : 2'b01;
                keep      = 1'b1;
            end
            SZ_WORD: begin
                lane_data = wr_data;
                lane_en   = 2'b11;
                keep      = 1'b1;
            end
            SZ_NONE: begin
                keep = 1'b0;
            end
        endcase
    end

    assign commit = wr_en && (tgt != TGT_NONE) && keep;

    // R2 / R3: a committed byte store carries the same byte in every lane
    always_comb begin
        if (commit && size == SZ_BYTE) begin
            assert_byte_copy_R2: assert (lane_data[15:8] == wr_data[7:0] &&
                                         lane_data[31:24] == wr_data[7:0]);
        end
    end
endmodule

// File: rtl/dmw_store.sv
module dmw_store #(
    parameter int WORDS = 256,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    lane_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [31:0]   wr_word,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_word
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            if (lane_en[0]) mem[wr_idx][15:0]  <= wr_word[15:0];
            if (lane_en[1]) mem[wr_idx][31:16] <= wr_word[31:16];
        end
        rd_word <= mem[rd_idx];
    end

    // R8: every store that commits touches at least one halfword lane
    assert_lanes_used_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (lane_en != 2'b00));
endmodule

// File: rtl/dispmem_write_adapter.sv
module dispmem_write_adapter
    import dmw_pkg::*;
#(
    parameter int PAL_BYTES        = 1024,
    parameter int OAM_BYTES        = 1024,
    parameter int VSECT_KEEP_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_size,
    input  logic [31:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic [2:0]  bg_mode,
    input  logic [31:0] rd_addr,
    output logic [15:0] rd_data
);
    localparam int PAL_AW    = $clog2(PAL_BYTES);
    localparam int OAM_AW    = $clog2(OAM_BYTES);
    localparam int VS_AW     = $clog2(VSECT_KEEP_BYTES);
    localparam int PAL_WORDS = PAL_BYTES / 4;
    localparam int OAM_WORDS = OAM_BYTES / 4;
    localparam int VS_WORDS  = VSECT_KEEP_BYTES / 4;

    target_e     w_tgt, r_tgt, r_tgt_q;
    logic [16:0] w_off, r_off;
    logic        commit;
    logic [1:0]  lane_en;
    logic [31:0] lane_data;
    logic        r_half_q;
    logic [2:0]  r_sect_q;

    logic                   pal_we, oam_we;
    logic [VSECT_COUNT-1:0] vs_we;
    logic [31:0]            pal_rd, oam_rd;
    logic [31:0]            vs_rd [VSECT_COUNT];
    logic [31:0]            sel_word;

    logic unused_off;
    assign unused_off = ^{w_off[1:0], w_off[13:VS_AW], r_off[0], r_off[13:VS_AW]};

    dmw_locate #(.PAL_BYTES(PAL_BYTES), .OAM_BYTES(OAM_BYTES)) u_wloc (
        .addr(wr_addr), .tgt(w_tgt), .off(w_off)
    );

    dmw_locate #(.PAL_BYTES(PAL_BYTES), .OAM_BYTES(OAM_BYTES)) u_rloc (
        .addr(rd_addr), .tgt(r_tgt), .off(r_off)
    );

    dmw_shape u_shape (
        .wr_en    (wr_en),
        .wr_size  (wr_size),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .bg_mode  (bg_mode),
        .tgt      (w_tgt),
        .commit   (commit),
        .lane_en  (lane_en),
        .lane_data(lane_data)
    );

    assign pal_we = commit && (w_tgt == TGT_PAL);
    assign oam_we = commit && (w_tgt == TGT_OAM);

    always_comb begin
        for (int s = 0; s < VSECT_COUNT; s++) begin
            vs_we[s] = commit && (w_tgt == TGT_VRAM) &&
                       (w_off[16:VSECT_SHIFT] == 3'(s));
        end
    end

    dmw_store #(.WORDS(PAL_WORDS)) u_pal (
        .clk(clk), .rst_n(rst_n), .we(pal_we), .lane_en(lane_en),
        .wr_idx(w_off[PAL_AW-1:2]), .wr_word(lane_data),
        .rd_idx(r_off[PAL_AW-1:2]), .rd_word(pal_rd)
    );

    dmw_store #(.WORDS(OAM_WORDS)) u_oam (
        .clk(clk), .rst_n(rst_n), .we(oam_we), .lane_en(lane_en),
        .wr_idx(w_off[OAM_AW-1:2]), .wr_word(lane_data),
        .rd_idx(r_off[OAM_AW-1:2]), .rd_word(oam_rd)
    );

    for (genvar s = 0; s < VSECT_COUNT; s++) begin : g_vsect
        dmw_store #(.WORDS(VS_WORDS)) u_vs (
            .clk(clk), .rst_n(rst_n), .we(vs_we[s]), .lane_en(lane_en),
            .wr_idx(w_off[VS_AW-1:2]), .wr_word(lane_data),
            .rd_idx(r_off[VS_AW-1:2]), .rd_word(vs_rd[s])
        );
    end

    // read path registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_tgt_q  <= TGT_NONE;
            r_half_q <= 1'b0;
            r_sect_q <= '0;
        end else begin
            r_tgt_q  <= r_tgt;
            r_half_q <= r_off[1];
            r_sect_q <= r_off[16:VSECT_SHIFT];
        end
    end

    always_comb begin
        sel_word = '0;
        unique case (r_tgt_q)
            TGT_PAL:  sel_word = pal_rd;
            TGT_OAM:  sel_word = oam_rd;
            TGT_VRAM: begin
                for (int s = 0; s < VSECT_COUNT; s++) begin
                    if (r_sect_q == 3'(s)) sel_word = vs_rd[s];
                end
            end
            TGT_NONE: sel_word = '0;
        endcase
        rd_data = r_half_q ? sel_word[31:16] : sel_word[15:0];
    end

    // R1: a write reaches at most one storage array
    assert_single_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pal_we, oam_we, vs_we}));

    // R1: foreign top byte never writes
    assert_foreign_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr[31:24] < 8'h05 || wr_addr[31:24] > 8'h07))
        |-> !(pal_we || oam_we || (|vs_we)));

    // R4: low-mode byte writes into the object tile area are dropped
    assert_obj_low_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'd0 && wr_addr[31:16] == 16'h0601 &&
         !wr_addr[15] && bg_mode <= 3'd2) |-> (vs_we == '0));

    // R5: high-mode byte writes into the upper object tile area are dropped
    assert_obj_high_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'd0 && wr_addr[31:16] == 16'h0601 &&
         wr_addr[15:14] == 2'b01 && bg_mode > 3'd2) |-> (vs_we == '0));

    // R7: object attribute store ignores byte writes
    assert_oam_byte_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'd0 && wr_addr[31:24] == 8'h07) |-> !oam_we);

    // R11: unmapped reads return zero one cycle later
    assert_unmapped_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[31:24] < 8'h05 || rd_addr[31:24] > 8'h07) |=> (rd_data == 16'h0000));
endmodule

// File: tb/dispmem_write_adapter_test.sv
`timescale 1ns/1ps
module dispmem_write_adapter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_size = 2'd3;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  bg_mode = '0;
    logic [31:0] rd_addr = 32'h0400_0000;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dispmem_write_adapter uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size),
        .wr_addr(wr_addr), .wr_data(wr_data), .bg_mode(bg_mode),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct packed {
        logic [1:0]  sz;    // 0 byte, 1 half, 2 word, 3 read only
        logic [2:0]  mode;
        logic [31:0] wa;
        logic [31:0] wd;
        logic [31:0] ra;
        logic [15:0] exp_v;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 3'd0, 32'h0500_0010, 32'h0000_1234, 32'h0500_0010, 16'h1234, 8'd8},  // R8
        '{2'd0, 3'd0, 32'h0500_0013, 32'h0000_00AB, 32'h0500_0012, 16'hABAB, 8'd2},  // R2
        '{2'd0, 3'd0, 32'h0500_0011, 32'h0000_005C, 32'h0500_0010, 16'h5C5C, 8'd2},  // R2
        '{2'd1, 3'd0, 32'h0500_0421, 32'h0000_7777, 32'h0500_0020, 16'h7777, 8'd9},  // R9
        '{2'd2, 3'd0, 32'h0500_0043, 32'hDEAD_BEEF, 32'h0500_0040, 16'hBEEF, 8'd8},  // R8
        '{2'd3, 3'd0, 32'h0,         32'h0,         32'h0500_0042, 16'hDEAD, 8'd8},  // R8
        '{2'd1, 3'd0, 32'h0600_0100, 32'h0000_1111, 32'h0600_0100, 16'h1111, 8'd3},  // R3
        '{2'd0, 3'd0, 32'h0600_0101, 32'h0000_0022, 32'h0600_0100, 16'h2222, 8'd3},  // R3
        '{2'd1, 3'd0, 32'h0601_0020, 32'h0000_3333, 32'h0601_0020, 16'h3333, 8'd4},  // R4
        '{2'd0, 3'd1, 32'h0601_0021, 32'h0000_0044, 32'h0601_0020, 16'h3333, 8'd4},  // R4
        '{2'd1, 3'd0, 32'h0601_4020, 32'h0000_5555, 32'h0601_4020, 16'h5555, 8'd5},  // R5
        '{2'd0, 3'd2, 32'h0601_4021, 32'h0000_0066, 32'h0601_4020, 16'h5555, 8'd4},  // R4
        '{2'd0, 3'd3, 32'h0601_0021, 32'h0000_0044, 32'h0601_0020, 16'h4444, 8'd5},  // R5
        '{2'd0, 3'd5, 32'h0601_4021, 32'h0000_0077, 32'h0601_4020, 16'h5555, 8'd5},  // R5
        '{2'd0, 3'd0, 32'h0601_8021, 32'h0000_00EE, 32'h0601_0020, 16'hEEEE, 8'd6},  // R6
        '{2'd0, 3'd7, 32'h0601_C020, 32'h0000_0088, 32'h0601_4020, 16'h8888, 8'd6},  // R6
        '{2'd1, 3'd0, 32'h0603_C030, 32'h0000_9999, 32'h0601_4030, 16'h9999, 8'd10}, // R10
        '{2'd1, 3'd0, 32'h0600_0200, 32'h0000_0A0A, 32'h0602_0200, 16'h0A0A, 8'd10}, // R10
        '{2'd1, 3'd0, 32'h0700_0050, 32'h0000_CAFE, 32'h0700_0050, 16'hCAFE, 8'd1},  // R1
        '{2'd0, 3'd0, 32'h0700_0050, 32'h0000_0011, 32'h0700_0050, 16'hCAFE, 8'd7},  // R7
        '{2'd0, 3'd4, 32'h0700_0051, 32'h0000_0011, 32'h0700_0050, 16'hCAFE, 8'd7},  // R7
        '{2'd2, 3'd0, 32'h0700_0460, 32'h0102_0304, 32'h0700_0062, 16'h0102, 8'd9},  // R9
        '{2'd1, 3'd0, 32'h0400_0010, 32'h0000_FFFF, 32'h0500_0010, 16'h5C5C, 8'd1},  // R1
        '{2'd3, 3'd0, 32'h0,         32'h0,         32'h0400_0010, 16'h0000, 8'd11}, // R11
        '{2'd2, 3'd0, 32'h0601_0043, 32'hAABB_CCDD, 32'h0601_0040, 16'hCCDD, 8'd4},  // R4
        '{2'd3, 3'd0, 32'h0,         32'h0,         32'h0601_0042, 16'hAABB, 8'd4},  // R4
        '{2'd0, 3'd4, 32'h0601_0051, 32'h0000_005A, 32'h0601_0050, 16'h5A5A, 8'd5},  // R5
        '{2'd1, 3'd0, 32'h0700_0002, 32'h0000_4321, 32'h0700_0402, 16'h4321, 8'd9}   // R9
    };

    task automatic check(input logic [15:0] got, input logic [15:0] want,
                         input int req, input string what);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, want);
        end
    endtask

    initial begin
        // R11: read port is zero while in reset and right after
        repeat (3) @(negedge clk);
        check(rd_data, 16'h0000, 11, "during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data, 16'h0000, 11, "after reset");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (VECS[i].sz != 2'd3) begin
                wr_en   = 1'b1;
                wr_size = VECS[i].sz;
                wr_addr = VECS[i].wa;
                wr_data = VECS[i].wd;
                bg_mode = VECS[i].mode;
            end
            @(negedge clk);
            wr_en   = 1'b0;
            wr_size = 2'd3;
            rd_addr = VECS[i].ra;
            @(negedge clk);
            check(rd_data, VECS[i].exp_v, int'(VECS[i].req), $sformatf("vector %0d", i));
        end

        // R11: one-cycle read latency
        @(negedge clk);
        rd_addr = 32'h0500_0040;
        @(negedge clk);
        check(rd_data, 16'hBEEF, 11, "latency first read");
        rd_addr = 32'h0500_0042;
        #1;
        check(rd_data, 16'hBEEF, 11, "latency old value held");
        @(negedge clk);
        check(rd_data, 16'hDEAD, 11, "latency new value");

        // R7: word write to attribute store still lands after byte drops
        wr_en = 1'b1; wr_size = 2'd2; wr_addr = 32'h0700_0050; wr_data = 32'h1357_2468;
        @(negedge clk);
        wr_en = 1'b0; wr_size = 2'd3; rd_addr = 32'h0700_0052;
        @(negedge clk);
        check(rd_data, 16'h1357, 7, "word write to attribute store");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule